// File: doc/BRIEF.md
# Serial audio output formatter

This block turns a stream of recovered stereo samples into a three-wire serial audio output: a bit clock, a word-select clock and a data line. It sits after the demodulator of a digital audio receiver. The bit clock is made by halving a clock-enable pulse that marks each period of a 128fs reference. Each frame holds 64 bit clocks: a 32-bit left slot while the word-select line is high, then a 32-bit right slot while it is low. A 2-bit format code picks where the sample sits in its slot and in which bit order it is sent.

Samples arrive as a left/right pair with a strobe. Each channel carries a parity-error flag, and a lock input reports whether the recovered clock is valid. The block hides short error bursts by sending the last good sample again. Longer bursts and loss of lock mute the output. The format code and both channel words are taken at the start of each left slot, so a frame never mixes two formats.

Top module: `aud_serial_fmt`

## Requirements
- R1: After reset, `bclk_o` toggles on every cycle that has `tick_128` high. A frame is 64 bit clocks. `lrck_o` is high for bit positions 0..31 (the left slot) and low for 32..63 (the right slot), and it changes only together with a falling edge of `bclk_o`.
- R2: `sdata_o` changes only on a falling edge of `bclk_o` (or when `locked` changes). Every slot position that does not carry a sample bit is driven low.
- R3: Format 0 (`fmt_sel`=2'b00): slot positions 16..31 carry sample bits 19 down to 4, with the MSB first. The 4 low bits are dropped.
- R4: Format 1 (2'b01): slot positions 12..31 carry sample bits 0 up to 19, with the LSB first.
- R5: Format 2 (2'b10): slot positions 12..31 carry sample bits 19 down to 0, with the MSB first.
- R6: Format 3 (2'b11): slot positions 0..19 carry sample bits 19 down to 0, with the MSB first.
- R7: The format code and both channel words are captured at the start of the left slot. A format change made in the middle of a frame first shows in the next frame.
- R8: A strobe with the channel's parity-error flag low stores that sample as the channel's held word and restarts the channel's error run.
- R9: The first 8 consecutive error strobes on a channel leave its held word unchanged, so the last good sample is sent again.
- R10: The 9th and every later consecutive error strobe on a channel set its held word to zero, until a good sample arrives.
- R11: While `locked` is low, `sdata_o` is low. Both held words are cleared and both error runs restart. Strobes are ignored.
- R12: During reset, `bclk_o`, `lrck_o` and `sdata_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_128 | input | 1 | One-cycle enable per 128fs reference period |
| fmt_sel | input | 2 | Slot format code (see R3..R6) |
| locked | input | 1 | Recovered clock is locked |
| smp_stb | input | 1 | New sample pair present |
| smp_l | input | 20 | Left sample |
| smp_r | input | 20 | Right sample |
| perr_l | input | 1 | Left sample has a parity error |
| perr_r | input | 1 | Right sample has a parity error |
| bclk_o | output | 1 | Bit clock (64fs) |
| lrck_o | output | 1 | Word select: high for left, low for right |
| sdata_o | output | 1 | Serial data |

## Verification
The hardest point to reach from the ports is the boundary between repeating and muting. The bench must apply more than eight consecutive error strobes to one channel, with no good sample and no loss of lock in between, and then see the output change at the 9th. A directed run of twelve error strobes on the left channel does this while the right channel takes random errors. A later good sample checks recovery. Format changes are applied in the middle of frames, so each frame's bits show whether the capture waited for the left-slot start.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;
  localparam int SMP_W   = 20;
  localparam int SHORT_W = 16;
  localparam int SLOT_W  = 32;
  localparam int POS_W   = $clog2(SLOT_W);
  localparam int FRAME_W = POS_W + 1;

  typedef enum logic [1:0] {
    FMT_RJ16_MSB = 2'b00,
    FMT_RJ20_LSB = 2'b01,
    FMT_RJ20_MSB = 2'b10,
    FMT_LJ20_MSB = 2'b11
  } fmt_e;

  // Bit placed at position p of a slot for the given format.
  function automatic logic slot_bit(input fmt_e f, input logic [SMP_W-1:0] w,
                                    input logic [POS_W-1:0] p);
    int pi;
    int idx;
    logic [SMP_W-1:0] sh;
    logic b;
    pi  = int'(p);
    b   = 1'b0;
    idx = 0;
    case (f)
      FMT_RJ16_MSB: if (pi >= SLOT_W - SHORT_W) begin
        idx = SMP_W - 1 - (pi - (SLOT_W - SHORT_W)); b = 1'b1;
      end
      FMT_RJ20_LSB: if (pi >= SLOT_W - SMP_W) begin
        idx = pi - (SLOT_W - SMP_W); b = 1'b1;
      end
      FMT_RJ20_MSB: if (pi >= SLOT_W - SMP_W) begin
        idx = SLOT_W - 1 - pi; b = 1'b1;
      end
      default: if (pi < SMP_W) begin
        idx = SMP_W - 1 - pi; b = 1'b1;
      end
    endcase
    sh = w >> idx;
    return b & sh[0];
  endfunction
endpackage

// File: rtl/aud_conceal.sv
module aud_conceal
  import aud_fmt_pkg::*;
#(
  parameter int W       = SMP_W,
  parameter int MAX_RUN = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         lock,
  input  logic         perr,
  input  logic [W-1:0] smp,
  output logic [W-1:0] held
);
  localparam int RW = $clog2(MAX_RUN + 2);
  localparam logic [RW-1:0] RUN_LIM = RW'(MAX_RUN);
  localparam logic [RW-1:0] RUN_SAT = RW'(MAX_RUN + 1);

  logic [RW-1:0] run_q;
  logic          err_stb;
  logic          mute_now;

  assign err_stb  = stb & lock & perr;
  assign mute_now = err_stb & (run_q >= RUN_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n || !lock) begin
      held  <= '0;
      run_q <= '0;
    end else if (stb) begin
      if (!perr) begin
        held  <= smp;
        run_q <= '0;
      end else begin
        if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
        if (mute_now) held <= '0;
      end
    end
  end

  p_good_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && lock && !perr) |=> (held == $past(smp)));
  p_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_stb && !mute_now) |=> $stable(held));
  p_mute_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mute_now |=> (held == '0));
  p_unlock_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> (held == '0));
endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
  import aud_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  fmt_e             fmt_in,
  input  logic [SMP_W-1:0] word_l,
  input  logic [SMP_W-1:0] word_r,
  output logic             bclk,
  output logic             lrck,
  output logic             data_raw
);
  logic [FRAME_W-1:0] pos_q;
  logic [FRAME_W-1:0] pos_n;
  logic               fall;
  logic               frame_start;
  fmt_e               fmt_sh;
  fmt_e               fmt_use;
  logic [SMP_W-1:0]   l_sh, r_sh, l_use, r_use;
  logic               bit_n;

  assign fall        = tick & bclk;
  assign pos_n       = pos_q + 1'b1;
  assign frame_start = fall & (pos_n == '0);
  assign fmt_use     = frame_start ? fmt_in : fmt_sh;
  assign l_use       = frame_start ? word_l : l_sh;
  assign r_use       = frame_start ? word_r : r_sh;
  assign bit_n       = slot_bit(fmt_use, pos_n[FRAME_W-1] ? r_use : l_use,
                                pos_n[POS_W-1:0]);
  assign lrck        = ~pos_q[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk     <= 1'b0;
      pos_q    <= '1;
      data_raw <= 1'b0;
      fmt_sh   <= FMT_RJ16_MSB;
      l_sh     <= '0;
      r_sh     <= '0;
    end else begin
      if (tick) bclk <= ~bclk;
      if (fall) begin
        pos_q    <= pos_n;
        data_raw <= bit_n;
      end
      if (frame_start) begin
        fmt_sh <= fmt_in;
        l_sh   <= word_l;
        r_sh   <= word_r;
      end
    end
  end

  p_bclk_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (bclk != $past(bclk)));
  p_lrck_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrck) |-> $past(fall));
  p_data_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_raw) |-> $past(fall));
  p_fmt_at_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_sh) |-> $past(frame_start));
endmodule

// File: rtl/aud_serial_fmt.sv
module aud_serial_fmt
  import aud_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_128,
  input  logic [1:0]       fmt_sel,
  input  logic             locked,
  input  logic             smp_stb,
  input  logic [SMP_W-1:0] smp_l,
  input  logic [SMP_W-1:0] smp_r,
  input  logic             perr_l,
  input  logic             perr_r,
  output logic             bclk_o,
  output logic             lrck_o,
  output logic             sdata_o
);
  localparam int NCH = 2;

  logic [SMP_W-1:0] smp_a  [NCH];
  logic             perr_a [NCH];
  logic [SMP_W-1:0] held_a [NCH];
  logic             data_raw;

  assign smp_a[0]  = smp_l;
  assign smp_a[1]  = smp_r;
  assign perr_a[0] = perr_l;
  assign perr_a[1] = perr_r;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    aud_conceal #(.W(SMP_W), .MAX_RUN(8)) i_conceal (
      .clk  (clk),
      .rst_n(rst_n),
      .stb  (smp_stb),
      .lock (locked),
      .perr (perr_a[c]),
      .smp  (smp_a[c]),
      .held (held_a[c])
    );
  end

  aud_serial_tx i_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_128),
    .fmt_in  (fmt_e'(fmt_sel)),
    .word_l  (held_a[0]),
    .word_r  (held_a[1]),
    .bclk    (bclk_o),
    .lrck    (lrck_o),
    .data_raw(data_raw)
  );

  assign sdata_o = data_raw & locked;

  p_unlock_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !sdata_o);
endmodule

// File: tb/test_aud_serial_fmt.sv
module test_aud_serial_fmt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_128 = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        locked = 1'b1;
  logic        smp_stb = 1'b0;
  logic [19:0] smp_l = '0, smp_r = '0;
  logic        perr_l = 1'b0, perr_r = 1'b0;
  logic        bclk_o, lrck_o, sdata_o;

  int vectors = 0;
  int miscompares = 0;

  aud_serial_fmt i_aud_serial_fmt (
    .clk(clk), .rst_n(rst_n), .tick_128(tick_128), .fmt_sel(fmt_sel),
    .locked(locked), .smp_stb(smp_stb), .smp_l(smp_l), .smp_r(smp_r),
    .perr_l(perr_l), .perr_r(perr_r), .bclk_o(bclk_o), .lrck_o(lrck_o),
    .sdata_o(sdata_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int tc = 0;
    forever begin
      @(posedge clk); #1;
      tc++;
      tick_128 = (tc % 2 == 0);
    end
  end

  // Bench model of concealment and slot layout
  logic [19:0] m_held [2];
  int          m_run  [2];
  string       cur_tag = "R12";

  function automatic logic [31:0] exp_slot(input logic [1:0] f, input logic [19:0] w);
    logic [31:0] s = '0;
    case (f)
      2'd0: for (int k = 0; k < 16; k++) s[31-k] = w[4+k];
      2'd1: for (int k = 0; k < 20; k++) s[12+k] = w[k];
      2'd2: for (int k = 0; k < 20; k++) s[31-k] = w[k];
      default: for (int k = 0; k < 20; k++) s[19-k] = w[k];
    endcase
    return s;
  endfunction

  task automatic model_ch(input int c, input logic lk, input logic pe, input logic [19:0] s);
    if (!lk) begin m_held[c] = '0; m_run[c] = 0; end
    else if (!pe) begin m_held[c] = s; m_run[c] = 0; end
    else begin
      if (m_run[c] >= 8) m_held[c] = '0;
      if (m_run[c] < 9) m_run[c]++;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic lk, input logic [19:0] l,
                       input logic [19:0] r, input logic pl, input logic pr, input string tag);
    @(posedge clk); #1;
    fmt_sel = f; locked = lk; smp_l = l; smp_r = r; perr_l = pl; perr_r = pr;
    smp_stb = 1'b1; cur_tag = tag;
    model_ch(0, lk, pl, l);
    model_ch(1, lk, pr, r);
    @(posedge clk); #1;
    smp_stb = 1'b0;
  endtask

  // Frame capture at bit clock rises, sampled on the falling clock edge
  logic [63:0] got_d, got_lr, got_lk;
  logic [1:0]  snap_fmt;
  logic [19:0] snap_l, snap_r;
  string       snap_tag;
  int          nb = 0;
  bit          started = 0;
  logic        bclk_p = 1'b0, lrck_p = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (lrck_o && !lrck_p) begin
        if (started && nb == 64) begin
          logic [63:0] e;
          e = {exp_slot(snap_fmt, snap_r), exp_slot(snap_fmt, snap_l)} & got_lk;
          check(got_d == e, {snap_tag, " R2 frame data"}, got_d, e);
          check(got_lr == 64'h0000_0000_FFFF_FFFF, "R1 word select per slot",
                got_lr, 64'h0000_0000_FFFF_FFFF);
        end
        started  = 1;
        nb       = 0;
        snap_fmt = fmt_sel;
        snap_l   = m_held[0];
        snap_r   = m_held[1];
        snap_tag = cur_tag;
      end
      if (bclk_o && !bclk_p && started && nb < 64) begin
        got_d[nb]  = sdata_o;
        got_lr[nb] = lrck_o;
        got_lk[nb] = locked;
        nb++;
      end
    end
    bclk_p = bclk_o;
    lrck_p = lrck_o;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E_3D4C));
    m_held[0] = '0; m_held[1] = '0; m_run[0] = 0; m_run[1] = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(bclk_o == 1'b0, "R12 bclk in reset", 64'(bclk_o), 64'd0);
    check(lrck_o == 1'b0, "R12 lrck in reset", 64'(lrck_o), 64'd0);
    check(sdata_o == 1'b0, "R12 sdata in reset", 64'(sdata_o), 64'd0);
    @(posedge clk); #1; rst_n = 1'b1;

    for (int f = 0; f < 64; f++) begin
      logic [1:0]  fm;
      logic        lk, pl, pr;
      string       tg;
      @(negedge lrck_o);
      repeat (40) @(posedge clk);
      fm = 2'($urandom_range(0, 3));
      lk = 1'b1;
      pl = ($urandom_range(0, 3) == 0);
      pr = ($urandom_range(0, 3) == 0);
      tg = "R7 random";
      if (f < 8) begin
        fm = 2'(f / 2); pl = 0; pr = 0;
        case (fm)
          2'd0: tg = "R3 format 0";
          2'd1: tg = "R4 format 1";
          2'd2: tg = "R5 format 2";
          default: tg = "R6 format 3";
        endcase
      end else if (f < 20) begin
        pl = 1'b1;
        tg = (f - 7 <= 8) ? "R9 repeat" : "R10 mute";
      end else if (f == 20 || f == 21) begin
        pl = 0; pr = 0; tg = "R8 recover";
      end else if (f == 24 || f == 25) begin
        lk = 1'b0; tg = "R11 unlocked";
      end else if (f == 26) begin
        pl = 0; pr = 0; tg = "R8 relock";
      end
      apply(fm, lk, 20'($urandom), 20'($urandom), pl, pr, tg);
    end
    @(posedge lrck_o);
    @(posedge lrck_o);
    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule